// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external, unclocked static RAM of 131,072 bytes. The host offers one transaction at a time: an address, a direction flag and, for writes, a data byte. The block answers with a one-cycle response pulse that carries the read byte. Only one transaction is in flight at a time. While an access is under way the block keeps its ready output low, and a request presented then simply waits.

On the memory side the block drives two chip enables of opposite polarity, an active-low write strobe, an active-low output enable and the address. The data bus is split into an output byte, an output-enable and an input byte, so the tri-state pad can sit at chip level. Every analogue timing figure is a parameter in nanoseconds. Each figure is turned into a whole number of clock cycles by ceiling division by the clock period, with a minimum of one cycle. Writes are timed by the write strobe with the output enable held inactive, which allows the shorter legal strobe width. All memory-side signals come straight from flops.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, both chip enables are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_wr_n`=1, `mem_rd_n`=1 and `mem_data_oe`=0.
- R2: Whenever `req_ready` is 1 the memory is deselected and the data bus is released. The memory counts as selected only when `mem_sel_n`=0 and `mem_sel`=1 together.
- R3: A write keeps `mem_rd_n`=1 throughout. It selects the memory one cycle before `mem_wr_n` falls, holds `mem_wr_n` low for exactly NWP = max(ceil(T_WP/T), ceil(T_DS/T), ceil(T_WC/T)-2, 1) cycles, and keeps the memory selected in the cycle after `mem_wr_n` rises.
- R4: During a write, `mem_data_oe`=1 and `mem_data_out` holds the request's byte unchanged from the cycle the memory is selected until `mem_wr_n` rises.
- R5: A read holds `mem_rd_n`=0 and `mem_wr_n`=1, with the memory selected, for exactly NRD = max(ceil(T_AA/T), ceil(T_RC/T)) cycles. `mem_data_in` is captured at the clock edge that ends the last of those cycles.
- R6: A write keeps the memory selected for 2+NWP cycles, which is never fewer than ceil(T_WC/T).
- R7: `mem_data_oe` is never 1 while `mem_rd_n`=0, and it stays 0 in the cycle after any cycle in which `mem_rd_n` was 0.
- R8: `rsp_valid` is a single-cycle pulse. It comes 2+NWP+1 clock edges after a write is accepted and NRD+1 edges after a read is accepted. For a read, `rsp_rdata` equals the captured byte.
- R9: A request is accepted only on an edge where `req_ready` is 1. `req_ready` goes low at the accepting edge and returns to 1 one cycle after the response pulse. A request held during that time is neither accepted nor lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller idle; a request is accepted this edge |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte read, valid with rsp_valid |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_data_out | output | DATA_W | Byte driven towards the memory |
| mem_data_oe | output | 1 | Drive enable for the data pad |
| mem_data_in | input | DATA_W | Byte returned by the memory |

## Verification
Two things can coincide. A new request can be waiting while the previous read is completing. A read can also be followed straight away by a write to the same address, so the memory's output turn-off and the controller's bus drive fall in neighbouring cycles. The bench provokes both by keeping `req_valid` high across back-to-back read and write requests. A behavioural memory model returns a marker byte until the access time has elapsed since its pins last changed, so a capture made too early is visible. The bench judges each run against its own cycle schedule of `req_ready` and `rsp_valid`, its own shadow memory, and per-pin checks for bus overlap and strobe run lengths.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_WHLD = 3'd4,
    ST_REL  = 3'd5
  } seq_st_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic wr_n;
    logic rd_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1, drive: 1'b0};

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // memory-side strobe pattern for each sequencer state
  function automatic strobe_t strobes_for(input seq_st_e s);
    strobe_t p;
    p = STROBE_IDLE;
    case (s)
      ST_RD: begin
        p.sel_n = 1'b0; p.sel = 1'b1; p.rd_n = 1'b0;
      end
      ST_WSET, ST_WHLD: begin
        p.sel_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1;
      end
      ST_WPUL: begin
        p.sel_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1; p.wr_n = 1'b0;
      end
      default: p = STROBE_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

  AST_TMR_LOAD_TAKES : assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !last); // R5
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int N_RD = 2,
  parameter int N_WP = 1,
  parameter int CW   = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  output seq_st_e state,
  output seq_st_e state_d,
  output logic    accept,
  output logic    capture
);
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_last;

  sram_cyc_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  assign accept  = (state == ST_IDLE) && req_valid;
  assign capture = (state == ST_RD) && tmr_last;

  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (req_valid) begin
        if (req_write) state_d = ST_WSET;
        else begin
          state_d  = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_RD - 1);
        end
      end
      ST_RD:   if (tmr_last) state_d = ST_REL;
      ST_WSET: begin
        state_d  = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = CW'(N_WP - 1);
      end
      ST_WPUL: if (tmr_last) state_d = ST_WHLD;
      ST_WHLD: state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  AST_REL_ONE_CYCLE : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REL) |=> (state == ST_IDLE)); // R8
  AST_HOLD_FOLLOWS_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WHLD) |-> ($past(state) == ST_WPUL)); // R3
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           state_d,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_data_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_data_out,
  output logic              mem_data_oe,
  output logic [DATA_W-1:0] rd_byte
);
  strobe_t stb_q;
  logic    selected;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= STROBE_IDLE;
    else        stb_q <= strobes_for(state_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr     <= '0;
      mem_data_out <= '0;
      rd_byte      <= '0;
    end else begin
      if (accept) begin
        mem_addr     <= req_addr;
        mem_data_out <= req_wdata;
      end
      if (capture) rd_byte <= mem_data_in;
    end
  end

  assign mem_sel_n   = stb_q.sel_n;
  assign mem_sel     = stb_q.sel;
  assign mem_wr_n    = stb_q.wr_n;
  assign mem_rd_n    = stb_q.rd_n;
  assign mem_data_oe = stb_q.drive;
  assign selected    = !mem_sel_n && mem_sel;

  AST_WR_KEEPS_OE_HIGH : assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> mem_rd_n); // R3
  AST_SEL_BEFORE_WE : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $past(selected)); // R3
  AST_SEL_AFTER_WE : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> selected); // R3
  AST_DATA_STEADY : assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_data_out) && mem_data_oe)); // R4
  AST_NO_BUS_FIGHT : assert property (@(posedge clk) disable iff (!rst_n)
    mem_data_oe |-> mem_rd_n); // R7
  AST_TURNAROUND_GAP : assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_rd_n) |-> !mem_data_oe); // R7
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 20,
  parameter int T_AA_NS = 20,
  parameter int T_WC_NS = 20,
  parameter int T_WP_NS = 10,
  parameter int T_DS_NS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_data_out,
  output logic              mem_data_oe,
  input  logic [DATA_W-1:0] mem_data_in
);
  localparam int N_RD  = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int N_WC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int N_WP  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)),
                              imax(N_WC - 2, 1));
  localparam int N_MAX = imax(N_RD, N_WP);
  localparam int CW    = imax($clog2(N_MAX + 1), 1);

  seq_st_e state, state_d;
  logic    accept, capture;

  sram_seq #(.N_RD(N_RD), .N_WP(N_WP), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .state(state), .state_d(state_d), .accept(accept), .capture(capture)
  );

  sram_pin_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_data_in(mem_data_in),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_data_out(mem_data_out),
    .mem_data_oe(mem_data_oe), .rd_byte(rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_REL);

  AST_IDLE_DESELECTED : assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && !mem_data_oe)); // R2
  AST_RSP_SINGLE : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_RSP_NOT_READY : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_ACCEPT_DROPS_READY : assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready); // R9
endmodule

// File: tb/sim_async_sram_ctrl.sv
module sim_async_sram_ctrl;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int CLK_NS = 10;
  localparam int T_RC = 20, T_AA = 20, T_WC = 20, T_WP = 10, T_DS = 8;
  localparam logic [DW-1:0] FLOAT_BYTE = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_data_oe;
  logic [DW-1:0] rsp_rdata, mem_data_out, mem_data_in;
  logic [AW-1:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  async_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS), .T_RC_NS(T_RC), .T_AA_NS(T_AA),
                    .T_WC_NS(T_WC), .T_WP_NS(T_WP), .T_DS_NS(T_DS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe), .mem_data_in(mem_data_in)
  );

  int n_checks = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle counts restated: smallest whole cycle count covering the interval
  function automatic int cyc_up(input int ns);
    int c = 0;
    while (c * CLK_NS < ns) c++;
    return (c == 0) ? 1 : c;
  endfunction
  int n_rd_b, n_wp_b, lat_w, lat_r;
  initial begin
    n_rd_b = cyc_up(T_AA) > cyc_up(T_RC) ? cyc_up(T_AA) : cyc_up(T_RC);
    n_wp_b = cyc_up(T_WP) > cyc_up(T_DS) ? cyc_up(T_WP) : cyc_up(T_DS);
    while (2 + n_wp_b < cyc_up(T_WC)) n_wp_b++;
    lat_w = 2 + n_wp_b + 1;
    lat_r = n_rd_b + 1;
  end

  // behavioural memory
  logic [DW-1:0] marr [int];
  logic [DW-1:0] shadow [int];
  logic rd_ok = 1'b0;
  logic [DW-1:0] rd_val = '0;
  int gen = 0;
  time t_dq = 0;
  wire sel_b = !mem_sel_n && mem_sel;

  function automatic logic [DW-1:0] peek(input int a);
    return marr.exists(a) ? marr[a] : '0;
  endfunction

  always @(mem_addr or mem_sel_n or mem_sel or mem_rd_n or mem_wr_n) begin
    gen++;
    rd_ok = 1'b0;
    fork
      begin
        automatic int g = gen;
        #(T_AA - 1);
        if (g == gen) begin
          rd_val = peek(int'(mem_addr));
          rd_ok  = 1'b1;
        end
      end
    join_none
  end
  assign mem_data_in = (sel_b && !mem_rd_n && mem_wr_n && rd_ok) ? rd_val : FLOAT_BYTE;

  always @(mem_data_out or mem_data_oe) t_dq = $time;
  always @(posedge mem_wr_n) begin
    if (sel_b) begin
      chk(mem_data_oe && ($time - t_dq >= T_DS), "R4 data setup before strobe end",
          int'($time - t_dq), T_DS);
      marr[int'(mem_addr)] = mem_data_out;
    end
  end

  // reference schedule
  int  cyc = 0;
  int  resp_cyc = -1, ready_cyc = 0;
  bit  exp_is_rd = 0;
  logic [DW-1:0] exp_data = '0;
  bit  started = 0;
  always @(posedge clk) if (rst_n) cyc++;

  bit prev_wr_n = 1, prev_rd_n = 1, prev_sel = 0, wr_seen = 0;
  logic [DW-1:0] prev_dq = '0;
  int we_run = 0, rd_run = 0, sel_run = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(req_ready && !rsp_valid && mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_data_oe,
          "R1 reset state", {req_ready, rsp_valid, mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_data_oe},
          7'b1010110);
    end else if (started) begin
      chk(rsp_valid == (cyc == resp_cyc), "R8 response timing", rsp_valid, cyc == resp_cyc);
      chk(req_ready == (cyc >= ready_cyc), "R9 ready schedule", req_ready, cyc >= ready_cyc);
      if (rsp_valid && exp_is_rd)
        chk(rsp_rdata == exp_data, "R5 read data", rsp_rdata, exp_data);
      if (req_ready)
        chk(!sel_b && !mem_data_oe, "R2 idle deselected", {sel_b, mem_data_oe}, 0);
      chk(!(mem_data_oe && !mem_rd_n), "R7 bus overlap", mem_data_oe, 0);
      if (!prev_rd_n) chk(!mem_data_oe, "R7 turnaround gap", mem_data_oe, 0);
      if (!mem_wr_n) begin
        chk(mem_rd_n, "R3 output enable high in write", mem_rd_n, 1);
        if (prev_wr_n) chk(prev_sel, "R3 select before strobe", prev_sel, 1);
        else chk(mem_data_out == prev_dq && mem_data_oe, "R4 data held", mem_data_out, prev_dq);
        we_run++;
        wr_seen = 1;
      end else if (!prev_wr_n) begin
        chk(we_run == n_wp_b, "R3 strobe width", we_run, n_wp_b);
        chk(sel_b, "R3 select after strobe", sel_b, 1);
        we_run = 0;
      end
      if (!mem_rd_n) rd_run++;
      else if (!prev_rd_n) begin
        chk(rd_run == n_rd_b, "R5 read length", rd_run, n_rd_b);
        rd_run = 0;
      end
      if (sel_b) sel_run++;
      else if (prev_sel) begin
        if (wr_seen) chk(sel_run == 2 + n_wp_b && sel_run >= cyc_up(T_WC), "R6 write cycle length",
                         sel_run, 2 + n_wp_b);
        sel_run = 0;
        wr_seen = 0;
      end
    end
    prev_wr_n = mem_wr_n; prev_rd_n = mem_rd_n; prev_sel = sel_b; prev_dq = mem_data_out;
  end

  // host requests: act 1 unit after the falling edge, after the checks
  task automatic issue(input bit w, input int a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) begin @(negedge clk); #1; end
    if (w) begin
      resp_cyc = cyc + lat_w; exp_is_rd = 0; shadow[a] = d;
    end else begin
      resp_cyc = cyc + lat_r; exp_is_rd = 1;
      exp_data = shadow.exists(a) ? shadow[a] : '0;
    end
    ready_cyc = resp_cyc + 1;
    @(posedge clk);
  endtask
  task automatic go_idle(input int n);
    @(negedge clk); #1;
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
    started = 1;
    // R3 R4 R6: back-to-back writes at both address extremes
    issue(1, 'h00000, 8'h3C);
    issue(1, 'h1FFFF, 8'hC3);
    issue(1, 'h0AAAA, 8'h55);
    // R5 R9: reads held back-to-back
    issue(0, 'h00000, 0);
    issue(0, 'h1FFFF, 0);
    issue(0, 'h0AAAA, 0);
    // R7: read immediately followed by write to the same place, then read
    issue(0, 'h1FFFF, 0);
    issue(1, 'h1FFFF, 8'h96);
    issue(0, 'h1FFFF, 0);
    go_idle(4);
    issue(1, 'h15555, 8'h00);
    go_idle(2);
    issue(0, 'h00123, 0);
    issue(1, 'h00000, 8'hFF);
    issue(0, 'h00000, 0);
    issue(0, 'h15555, 0);
    go_idle(8);
    chk(peek('h1FFFF) == 8'h96, "R3 memory content", peek('h1FFFF), 8'h96);
    chk(peek('h0AAAA) == 8'h55, "R4 memory content", peek('h0AAAA), 8'h55);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog expired actual=busy expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule